// File: doc/BRIEF.md
# I2C Serial EEPROM Target Controller

This block is the digital core of a byte-addressed serial memory that answers as a target on a two-wire I2C bus. A fast system clock samples the bus clock and data lines. Each line passes through a sample-count glitch filter before START, STOP and clock edges are extracted. Three strap inputs personalise the select code, so eight such devices can share one bus. The only bus output is an enable for the open-drain pull-down on the data line.

A host writes one byte, or a page of up to 32 bytes, after a two-byte word address. The bytes collect in a page buffer and go into the storage array only when the closing STOP arrives. A timed write cycle follows, during which the device does not answer its select code, so the host can poll for completion. A write-protect input that is high at that STOP discards the buffered bytes and starts no write cycle. Reads come in three forms: from the current address, from an address loaded by a dummy write followed by a repeated START, and sequential reads that run on while the host acknowledges.

The word address is 13 bits. The storage depth is 2^ARRAY_AW bytes. When ARRAY_AW is below 13, addresses alias modulo that depth; set ARRAY_AW to 13 for the full 8192-byte array.

Top module: `i2c_eeprom_target`

## Requirements
- R1: The select byte is binary 1010 in bits 7:4, the strap value in bits 3:1 and a direction flag in bit 0 (1 means read). The device acknowledges it by pulling SDA low during the ninth clock only when the byte matches and no write cycle is running. Otherwise it leaves SDA released and ignores the bus until the next START.
- R2: After a write select, the first address byte supplies word-address bits 12:8 from its bits 4:0 and its bits 7:5 are ignored. The second byte supplies bits 7:0. Both bytes are acknowledged.
- R3: Each write data byte is acknowledged and buffered at the current address. Only address bits 4:0 then advance, wrapping modulo 32, while bits 12:5 stay fixed. A byte sent to a slot already filled in the same transaction replaces the earlier one.
- R4: A STOP ending a write that carried at least one data byte, with write-protect low, commits the buffered bytes to the array. It also starts a busy period of WR_CYCLES clock cycles. Select bytes are not acknowledged during that period and are acknowledged again after it.
- R5: If write-protect is high when that STOP is seen, the buffered bytes are dropped, the array keeps its contents, and no busy period starts.
- R6: A random read is a write select and two address bytes, then a repeated START and a read select. It returns the byte at the loaded address first.
- R7: A current-address read starts at the address counter, which after a read is one past the last byte sent.
- R8: During a read, each host acknowledge moves on to the next address across all 13 bits, and address 0x1FFF is followed by 0x0000.
- R9: The device starts pulling SDA low only while the filtered SCL is low, and sends data MSB first. After a host NACK it releases SDA and ignores the bus until the next START.
- R10: Pulses on SCL or SDA shorter than FILT_LEN clock samples are ignored.
- R11: After reset, SDA is released and no busy period is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| strap | input | 3 | Select-code strap value |
| wp | input | 1 | Write protect, high blocks array updates |
| sda_pull | output | 1 | High to pull the data line low |

## Verification
Two pairs of events can land together. The first is the STOP that would launch a commit and a high write-protect level. The bench raises write-protect across such a STOP and judges the outcome twice: an immediate select must be acknowledged, because no busy period started, and a read of the target byte must return the earlier value. The second pair is a select decode and a busy period still running. The bench polls right after a page STOP and expects no acknowledge, then polls again after WR_CYCLES and expects one.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam logic [3:0] SEL_PREFIX = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RDAT_ACK
    } bus_st_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    function automatic logic sel_match(input logic [7:0] b, input logic [2:0] strap);
        return b[7:1] == {SEL_PREFIX, strap};
    endfunction

endpackage

// File: rtl/eep_filter.sv
module eep_filter #(
    parameter int FILT_LEN = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
            dout   <= 1'b1;
            run    <= '0;
        end else begin
            sync_q <= {sync_q[0], din};
            if (sync_q[1] == dout) begin
                run <= '0;
            end else if (run == CW'(FILT_LEN - 1)) begin
                dout <= sync_q[1];
                run  <= '0;
            end else begin
                run <= run + 1'b1;
            end
        end
    end

    AST_FILT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (dout != $past(dout)) |-> (dout == $past(sync_q[1]))); // R10

endmodule

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
    parameter int WR_CYCLES = 1250000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(WR_CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(WR_CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);

    AST_BUSY_ARMS: assert property (@(posedge clk) disable iff (rst)
        start |=> busy); // R4

endmodule

// File: rtl/eep_page_store.sv
module eep_page_store #(
    parameter int ARRAY_AW   = 12,
    parameter int PAGE_BYTES = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [$clog2(PAGE_BYTES)-1:0]  wr_off,
    input  logic [7:0]                     wr_data,
    input  logic                           clear,
    input  logic                           commit,
    input  logic [ARRAY_AW-$clog2(PAGE_BYTES)-1:0] page,
    input  logic [ARRAY_AW-1:0]            rd_addr,
    output logic [7:0]                     rd_data
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int PG_W  = ARRAY_AW - OFF_W;
    localparam int DEPTH = 1 << ARRAY_AW;

    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld;
    logic [PG_W-1:0]       page_q;
    logic [OFF_W-1:0]      walk;
    logic                  active;
    logic [7:0]            mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) pbuf[wr_off] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld    <= '0;
            active <= 1'b0;
            walk   <= '0;
            page_q <= '0;
        end else begin
            if (clear) begin
                vld <= '0;
            end else begin
                if (wr_en)  vld[wr_off] <= 1'b1;
                if (active) vld[walk]   <= 1'b0;
            end
            if (commit) begin
                active <= 1'b1;
                walk   <= '0;
                page_q <= page;
            end else if (active) begin
                walk <= walk + 1'b1;
                if (walk == OFF_W'(PAGE_BYTES - 1)) active <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (active && vld[walk]) mem[{page_q, walk}] <= pbuf[walk];
        rd_data <= mem[rd_addr];
    end

    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        commit |-> !active); // R4

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
    import eep_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int ARRAY_AW   = 12,
    parameter int PAGE_BYTES = 32,
    parameter int FILT_LEN   = 25,
    parameter int WR_CYCLES  = 1250000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [2:0] strap,
    input  logic       wp,
    output logic       sda_pull
);
    localparam int OFF_W = $clog2(PAGE_BYTES);

    logic [1:0] raw_lines, flt_lines;
    logic       scl_f, sda_f, scl_p, sda_p;
    bus_ev_t    ev;
    bus_st_e    st;
    logic [3:0] bitcnt;
    logic [7:0] shreg, tx;
    logic [ADDR_W-1:0] addr;
    logic       rw, pending, busy;
    logic       buf_we, buf_clr, commit_req;
    logic [OFF_W-1:0] buf_off;
    logic [7:0] buf_din, rd_data;

    assign raw_lines = {scl_in, sda_in};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        eep_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk (clk),
            .rst (rst),
            .din (raw_lines[g]),
            .dout(flt_lines[g])
        );
    end

    assign scl_f = flt_lines[1];
    assign sda_f = flt_lines[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    always_comb begin
        ev.start = scl_f && scl_p && sda_p && !sda_f;
        ev.stop  = scl_f && scl_p && !sda_p && sda_f;
        ev.rise  = scl_f && !scl_p;
        ev.fall  = !scl_f && scl_p;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            bitcnt     <= '0;
            shreg      <= '0;
            tx         <= '0;
            addr       <= '0;
            rw         <= 1'b0;
            pending    <= 1'b0;
            sda_pull   <= 1'b0;
            buf_we     <= 1'b0;
            buf_clr    <= 1'b0;
            buf_off    <= '0;
            buf_din    <= '0;
            commit_req <= 1'b0;
        end else begin
            buf_we     <= 1'b0;
            buf_clr    <= 1'b0;
            commit_req <= 1'b0;
            if (ev.stop) begin
                st       <= ST_IDLE;
                sda_pull <= 1'b0;
                pending  <= 1'b0;
                if (pending) begin
                    if (wp) buf_clr    <= 1'b1;
                    else    commit_req <= 1'b1;
                end
            end else if (ev.start) begin
                st       <= ST_DEV;
                bitcnt   <= '0;
                sda_pull <= 1'b0;
                pending  <= 1'b0;
                if (pending) buf_clr <= 1'b1;
            end else begin
                unique case (st)
                    ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
                        if (ev.rise) begin
                            shreg  <= {shreg[6:0], sda_f};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.fall && bitcnt == 4'd8) begin
                            if (st == ST_DEV) begin
                                if (sel_match(shreg, strap) && !busy) begin
                                    sda_pull <= 1'b1;
                                    rw       <= shreg[0];
                                    st       <= ST_DEV_ACK;
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end else if (st == ST_AHI) begin
                                addr[ADDR_W-1:8] <= shreg[ADDR_W-9:0];
                                sda_pull         <= 1'b1;
                                st               <= ST_AHI_ACK;
                            end else if (st == ST_ALO) begin
                                addr[7:0] <= shreg;
                                sda_pull  <= 1'b1;
                                st        <= ST_ALO_ACK;
                            end else begin
                                buf_we             <= 1'b1;
                                buf_off            <= addr[OFF_W-1:0];
                                buf_din            <= shreg;
                                addr[OFF_W-1:0]    <= addr[OFF_W-1:0] + 1'b1;
                                pending            <= 1'b1;
                                sda_pull           <= 1'b1;
                                st                 <= ST_WDAT_ACK;
                            end
                        end
                    end
                    ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK: begin
                        if (ev.fall) begin
                            bitcnt <= '0;
                            if (st == ST_DEV_ACK && rw) begin
                                tx       <= rd_data;
                                sda_pull <= ~rd_data[7];
                                st       <= ST_RDAT;
                            end else begin
                                sda_pull <= 1'b0;
                                case (st)
                                    ST_DEV_ACK: st <= ST_AHI;
                                    ST_AHI_ACK: st <= ST_ALO;
                                    default:    st <= ST_WDAT;
                                endcase
                            end
                        end
                    end
                    ST_RDAT: begin
                        if (ev.rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_pull <= 1'b0;
                                addr     <= addr + 1'b1;
                                st       <= ST_RDAT_ACK;
                            end else begin
                                tx       <= {tx[6:0], 1'b1};
                                sda_pull <= ~tx[6];
                            end
                        end
                    end
                    ST_RDAT_ACK: begin
                        if (ev.rise && sda_f) begin
                            st <= ST_IDLE;
                        end else if (ev.fall) begin
                            tx       <= rd_data;
                            sda_pull <= ~rd_data[7];
                            bitcnt   <= '0;
                            st       <= ST_RDAT;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    eep_busy_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .start(commit_req),
        .busy (busy)
    );

    eep_page_store #(.ARRAY_AW(ARRAY_AW), .PAGE_BYTES(PAGE_BYTES)) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (buf_we),
        .wr_off (buf_off),
        .wr_data(buf_din),
        .clear  (buf_clr),
        .commit (commit_req),
        .page   (addr[ARRAY_AW-1:OFF_W]),
        .rd_addr(addr[ARRAY_AW-1:0]),
        .rd_data(rd_data)
    );

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !scl_f); // R9

    AST_TX_BIT_HELD: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RDAT && scl_f) |-> (sda_pull == !tx[7])); // R9

    AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RDAT_ACK && ev.rise && sda_f && !ev.stop) |=> (st == ST_IDLE && !sda_pull)); // R9

    AST_BUSY_DEAF: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DEV && ev.fall && bitcnt == 4'd8 && busy && !ev.start && !ev.stop) |=> !sda_pull); // R4

    AST_WP_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
        commit_req |-> !$past(wp)); // R5

    AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WDAT_ACK && $past(st) == ST_WDAT) |->
        (addr[ADDR_W-1:OFF_W] == $past(addr[ADDR_W-1:OFF_W]))); // R3

endmodule

// File: tb/i2c_eeprom_target_test.sv
module i2c_eeprom_target_test;

    localparam int Q    = 24;
    localparam int FILT = 8;
    localparam int WRC  = 2000;
    localparam int AW   = 12;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic [2:0] strap = STRAP;
    logic sda_pull;
    logic sda_line;

    int ncmp = 0;
    int nbad = 0;
    int viol = 0;
    logic prev_pull = 1'b0;

    logic [7:0] refm [1 << AW];
    logic [7:0] pat  [64];

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    i2c_eeprom_target #(
        .ADDR_W(13), .ARRAY_AW(AW), .PAGE_BYTES(32),
        .FILT_LEN(FILT), .WR_CYCLES(WRC)
    ) uut (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
        .strap(strap), .wp(wp), .sda_pull(sda_pull)
    );

    // R9 monitor: a new pull-down must never begin while SCL is high
    always @(posedge clk) begin
        if (!rst && sda_pull && !prev_pull && scl_m) viol++;
        prev_pull <= sda_pull;
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        ncmp++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            if (glitch && i == 3) begin
                wq(4); scl_m = 1'b1; wq(3); scl_m = 1'b0; wq(Q - 7);
            end else begin
                wq(Q);
            end
            scl_m = 1'b1; wq(2 * Q);
            scl_m = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        ack = !sda_line;
        wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wq(Q);
            scl_m = 1'b1; wq(Q);
            d[i] = sda_line;
            wq(Q);
            scl_m = 1'b0; wq(Q);
        end
        sda_m = !mack; wq(Q);
        scl_m = 1'b1; wq(2 * Q);
        scl_m = 1'b0; wq(Q);
        sda_m = 1'b1;
    endtask

    function automatic int ridx(input logic [12:0] a);
        return int'(a) % (1 << AW);
    endfunction

    task automatic do_write(input logic [12:0] a, input int first, input int n,
                            input logic [2:0] junk, input bit glitch, input string tag);
        bit ack;
        bus_start();
        send_byte({4'b1010, STRAP, 1'b0}, 1'b0, ack);
        chk({tag, " R1 select"}, ack, 1);
        send_byte({junk, a[12:8]}, 1'b0, ack);
        chk({tag, " R2 addr hi"}, ack, 1);
        send_byte(a[7:0], glitch, ack);
        chk({tag, " R2 addr lo"}, ack, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(pat[first + k], 1'b0, ack);
            chk({tag, " R3 data ack"}, ack, 1);
            if (!wp) refm[ridx({a[12:5], 5'((int'(a[4:0]) + k) % 32)})] = pat[first + k];
        end
        bus_stop();
    endtask

    task automatic rand_read(input logic [12:0] a, input int n, input string tag);
        bit ack;
        logic [7:0] d;
        bus_start();
        send_byte({4'b1010, STRAP, 1'b0}, 1'b0, ack);
        send_byte({3'b000, a[12:8]}, 1'b0, ack);
        send_byte(a[7:0], 1'b0, ack);
        bus_start();
        send_byte({4'b1010, STRAP, 1'b1}, 1'b0, ack);
        chk({tag, " R6 read select"}, ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, d);
            chk(tag, d, refm[ridx(13'((int'(a) + k) % 8192))]);
        end
        wq(Q);
        chk({tag, " R9 released after NACK"}, sda_pull, 0);
        bus_stop();
    endtask

    task automatic poll(input bit exp_ack, input string tag);
        bit ack;
        bus_start();
        send_byte({4'b1010, STRAP, 1'b0}, 1'b0, ack);
        chk(tag, ack, exp_ack);
        bus_stop();
    endtask

    initial begin
        bit ack;
        logic [7:0] d;
        for (int k = 0; k < 40; k++) pat[k] = 8'((k * 37 + 11) % 256);
        pat[40] = 8'h5A; pat[41] = 8'hA5; pat[42] = 8'hC3; pat[43] = 8'h3C;
        pat[44] = 8'hFF; pat[45] = 8'h77;

        wq(5);
        rst = 1'b0;
        wq(3);
        chk("R11 sda released at reset", sda_pull, 0);

        // R1: sweep every strap code in the select byte, plus a wrong prefix
        for (int c = 0; c < 8; c++) begin
            bus_start();
            send_byte({4'b1010, 3'(c), 1'b0}, 1'b0, ack);
            chk("R1 select code sweep", ack, (3'(c) == STRAP) ? 1 : 0);
            chk("R1 no drive after select", sda_pull, 0);
            bus_stop();
        end
        bus_start();
        send_byte({4'b1011, STRAP, 1'b0}, 1'b0, ack);
        chk("R1 wrong prefix", ack, 0);
        bus_stop();
        strap = 3'b010;
        bus_start();
        send_byte({4'b1010, 3'b010, 1'b1}, 1'b0, ack);
        chk("R1 changed strap", ack, 1);
        recv_byte(1'b0, d);
        bus_stop();
        strap = STRAP;

        // R3/R4: 34 bytes wrap in page 0x0A20, junk in upper address bits (R2)
        do_write(13'h0A3C, 0, 34, 3'b111, 1'b0, "page");
        poll(1'b0, "R4 busy after commit");
        wq(WRC);
        poll(1'b1, "R4 ready after busy");
        rand_read(13'h0A20, 32, "R3 R6 page contents");

        // R8: rollover across the top of the address space
        do_write(13'h0000, 40, 2, 3'b000, 1'b0, "low");
        wq(WRC + 100);
        do_write(13'h1FFE, 42, 2, 3'b101, 1'b0, "top");
        wq(WRC + 100);
        rand_read(13'h1FFE, 3, "R8 rollover");

        // R7: current-address read continues at 0x0001
        bus_start();
        send_byte({4'b1010, STRAP, 1'b1}, 1'b0, ack);
        chk("R7 select", ack, 1);
        recv_byte(1'b0, d);
        chk("R7 current address", d, refm[1]);
        bus_stop();

        // R5: write protect high at STOP
        wp = 1'b1;
        do_write(13'h0000, 44, 1, 3'b000, 1'b0, "wp");
        wp = 1'b0;
        poll(1'b1, "R5 no busy under protect");
        rand_read(13'h0000, 1, "R5 array unchanged");

        // R10: short SCL pulse inside the address byte
        do_write(13'h0002, 45, 1, 3'b000, 1'b1, "R10");
        wq(WRC + 100);
        rand_read(13'h0002, 1, "R10 glitch ignored");

        chk("R9 drive begins with SCL low", viol, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        ncmp++;
        nbad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
        $finish;
    end

endmodule